// File: doc/BRIEF.md
# Integer Future File with Producer Tag Check

This block holds the integer register state of an out-of-order core in two copies. A committed copy of the architectural registers is written only at retirement. A speculative future copy is read at dispatch. Each future entry carries a valid bit and the reorder-buffer tag of its newest pending producer. A small set of scratch registers sits beside the committed copy. The scratch registers are used by multi-step operation sequences and are never renamed.

When an operation dispatches, its source indices are looked up combinationally. If a future entry is valid, the consumer takes the value. If the entry is not valid, the consumer takes the stored producer tag and waits for that tag's result broadcast. The destination entry is then stamped with the dispatching tag and marked pending. A completing result is written into the future entry only when its tag still matches the stamped one, so that only the last dispatched writer lands. A flush after a mispredict or an exception copies the whole committed copy into the future copy in one cycle. No free list is involved.

Top module: `iff_regfile`

## Requirements
- R1: After reset every index reads ready with value 0.
- R2: A source index 0..15 whose future entry is valid reads ready, with the future value on the data output.
- R3: A source index 0..15 whose future entry is pending reads not ready, with the stored producer tag on the tag output.
- R4: A dispatch with the destination enable set and a destination index 0..15 leaves that entry pending, with the dispatch tag, from the next cycle. A source lookup in the same cycle still sees the state from before the dispatch. With the dispatch enable low, nothing changes.
- R5: A completion to index 0..15 whose tag equals the stored tag writes the data and makes the entry ready from the next cycle.
- R6: A completion whose tag differs from the stored tag leaves the entry's value, ready state and tag unchanged.
- R7: When a dispatch and a completion hit the same entry in one cycle, the dispatch's tag and pending mark win.
- R8: A retirement to index 0..23 writes the committed copy. For indices 0..15 this does not change the future value until a flush.
- R9: A flush loads every future entry with the committed value held before that edge and marks it ready. Dispatch and completion in the flush cycle are ignored. A retirement in the flush cycle still updates the committed copy.
- R10: Indices 16..23 are scratch registers. They always read ready, with the committed scratch value, which changes one cycle after a retirement. Indices 24..31 read ready with value 0. Dispatches and completions to any index of 16 or above have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Restore the future copy from the committed copy |
| disp_en | input | 1 | An operation dispatches this cycle |
| disp_dst_en | input | 1 | The dispatching operation writes a destination |
| disp_dst | input | 5 | Destination register index |
| disp_tag | input | 8 | Reorder-buffer tag of the dispatching operation |
| src_idx | input | 2x5 | Source register indices, one per lookup port |
| src_ready | output | 2 | Source value is available |
| src_data | output | 2x32 | Source value, meaningful when ready |
| src_tag | output | 2x8 | Pending producer tag, meaningful when not ready |
| cmp_en | input | 1 | A result completes this cycle |
| cmp_idx | input | 5 | Destination index of the completing result |
| cmp_tag | input | 8 | Tag of the completing result |
| cmp_data | input | 32 | Completing result value |
| ret_en | input | 1 | A result retires this cycle |
| ret_idx | input | 5 | Retiring destination index |
| ret_data | input | 32 | Retiring value |

## Verification
A directed sequence drives one register through each case in turn. These are: a dispatch whose source equals its own destination, a stale completion, a dispatch that collides with a completion, and a matching completion. Each is told apart by the tag or value read back the next cycle. A flush is issued while a dispatch, a completion and a retirement are also active. This separates the pre-edge committed value from the value retired in the same cycle. Scratch and out-of-range indices are hit with dispatches and completions to show that they are left alone. A long random phase then mixes all four operations. Half of the completions carry the currently stamped tag, so matching and stale writes both occur often.

// File: rtl/ff_pkg.sv
package ff_pkg;
  typedef enum logic [1:0] {
    RGN_ARCH = 2'd0,
    RGN_SCR  = 2'd1,
    RGN_NONE = 2'd2
  } ff_region_e;

  function automatic ff_region_e ff_region(input int unsigned idx,
                                           input int unsigned n_arch,
                                           input int unsigned n_scr);
    if (idx < n_arch)              return RGN_ARCH;
    else if (idx < n_arch + n_scr) return RGN_SCR;
    else                           return RGN_NONE;
  endfunction
endpackage

// File: rtl/ff_future_entry.sv
module ff_future_entry #(
  parameter int DATA_W = 32,
  parameter int TAG_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush_i,
  input  logic [DATA_W-1:0] restore_i,
  input  logic              disp_hit_i,
  input  logic [TAG_W-1:0]  disp_tag_i,
  input  logic              cmp_hit_i,
  input  logic [TAG_W-1:0]  cmp_tag_i,
  input  logic [DATA_W-1:0] cmp_data_i,
  output logic [DATA_W-1:0] val_o,
  output logic              vld_o,
  output logic [TAG_W-1:0]  tag_o
);
  logic [DATA_W-1:0] val_q, val_d;
  logic              vld_q, vld_d;
  logic [TAG_W-1:0]  tag_q, tag_d;
  logic              tag_match, upd;

  assign tag_match = cmp_hit_i && (cmp_tag_i == tag_q);
  assign upd       = flush_i || disp_hit_i || tag_match;

  always_comb begin
    val_d = val_q;
    vld_d = vld_q;
    tag_d = tag_q;
    if (flush_i) begin
      val_d = restore_i;
      vld_d = 1'b1;
    end else if (disp_hit_i) begin
      tag_d = disp_tag_i;
      vld_d = 1'b0;
    end else if (tag_match) begin
      val_d = cmp_data_i;
      vld_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q <= '0;
      vld_q <= 1'b1;
      tag_q <= '0;
    end else if (upd) begin
      val_q <= val_d;
      vld_q <= vld_d;
      tag_q <= tag_d;
    end
  end

  assign val_o = val_q;
  assign vld_o = vld_q;
  assign tag_o = tag_q;
endmodule

// File: rtl/ff_commit_bank.sv
module ff_commit_bank #(
  parameter int DATA_W = 32,
  parameter int N_ENT  = 24,
  parameter int IDX_W  = 5
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          ret_en_i,
  input  logic [IDX_W-1:0]              ret_idx_i,
  input  logic [DATA_W-1:0]             ret_data_i,
  output logic [N_ENT-1:0][DATA_W-1:0]  val_o
);
  for (genvar i = 0; i < N_ENT; i++) begin : g_ent
    logic              we;
    logic [DATA_W-1:0] q;
    assign we = ret_en_i && (ret_idx_i == IDX_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (we) q <= ret_data_i;
    end
    assign val_o[i] = q;
  end
endmodule

// File: rtl/ff_read_port.sv
module ff_read_port
  import ff_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int TAG_W  = 8,
  parameter int N_ARCH = 16,
  parameter int N_SCR  = 8,
  parameter int IDX_W  = 5,
  localparam int AW    = $clog2(N_ARCH),
  localparam int N_ENT = N_ARCH + N_SCR
) (
  input  logic [IDX_W-1:0]              idx_i,
  input  logic [N_ARCH-1:0][DATA_W-1:0] fut_val_i,
  input  logic [N_ARCH-1:0]             fut_vld_i,
  input  logic [N_ARCH-1:0][TAG_W-1:0]  fut_tag_i,
  input  logic [N_ENT-1:0][DATA_W-1:0]  com_val_i,
  output logic                          ready_o,
  output logic [DATA_W-1:0]             data_o,
  output logic [TAG_W-1:0]              tag_o
);
  ff_region_e rgn;
  logic [AW-1:0] asel;

  assign rgn  = ff_region(32'(idx_i), N_ARCH, N_SCR);
  assign asel = idx_i[AW-1:0];

  always_comb begin
    ready_o = 1'b1;
    data_o  = '0;
    tag_o   = '0;
    unique case (rgn)
      RGN_ARCH: begin
        ready_o = fut_vld_i[asel];
        data_o  = fut_val_i[asel];
        tag_o   = fut_tag_i[asel];
      end
      RGN_SCR:  data_o = com_val_i[idx_i];
      default:  data_o = '0;
    endcase
  end
endmodule

// File: rtl/iff_regfile.sv
module iff_regfile #(
  parameter int DATA_W = 32,
  parameter int TAG_W  = 8,
  parameter int N_ARCH = 16,
  parameter int N_SCR  = 8,
  parameter int N_SRC  = 2,
  localparam int N_ENT = N_ARCH + N_SCR,
  localparam int IDX_W = $clog2(N_ENT)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         flush,
  input  logic                         disp_en,
  input  logic                         disp_dst_en,
  input  logic [IDX_W-1:0]             disp_dst,
  input  logic [TAG_W-1:0]             disp_tag,
  input  logic [N_SRC-1:0][IDX_W-1:0]  src_idx,
  output logic [N_SRC-1:0]             src_ready,
  output logic [N_SRC-1:0][DATA_W-1:0] src_data,
  output logic [N_SRC-1:0][TAG_W-1:0]  src_tag,
  input  logic                         cmp_en,
  input  logic [IDX_W-1:0]             cmp_idx,
  input  logic [TAG_W-1:0]             cmp_tag,
  input  logic [DATA_W-1:0]            cmp_data,
  input  logic                         ret_en,
  input  logic [IDX_W-1:0]             ret_idx,
  input  logic [DATA_W-1:0]            ret_data
);
  logic [N_ARCH-1:0][DATA_W-1:0] fut_val;
  logic [N_ARCH-1:0]             fut_valid;
  logic [N_ARCH-1:0][TAG_W-1:0]  fut_tag;
  logic [N_ENT-1:0][DATA_W-1:0]  com_val;
  logic                          disp_live, cmp_live;

  assign disp_live = disp_en && disp_dst_en && !flush;
  assign cmp_live  = cmp_en && !flush;

  ff_commit_bank #(.DATA_W(DATA_W), .N_ENT(N_ENT), .IDX_W(IDX_W)) u_commit (
    .clk        (clk),
    .rst_n      (rst_n),
    .ret_en_i   (ret_en),
    .ret_idx_i  (ret_idx),
    .ret_data_i (ret_data),
    .val_o      (com_val)
  );

  for (genvar i = 0; i < N_ARCH; i++) begin : g_fut
    logic d_hit, c_hit;
    assign d_hit = disp_live && (disp_dst == IDX_W'(i));
    assign c_hit = cmp_live && (cmp_idx == IDX_W'(i));
    ff_future_entry #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_ent (
      .clk        (clk),
      .rst_n      (rst_n),
      .flush_i    (flush),
      .restore_i  (com_val[i]),
      .disp_hit_i (d_hit),
      .disp_tag_i (disp_tag),
      .cmp_hit_i  (c_hit),
      .cmp_tag_i  (cmp_tag),
      .cmp_data_i (cmp_data),
      .val_o      (fut_val[i]),
      .vld_o      (fut_valid[i]),
      .tag_o      (fut_tag[i])
    );
  end

  for (genvar p = 0; p < N_SRC; p++) begin : g_src
    ff_read_port #(
      .DATA_W(DATA_W), .TAG_W(TAG_W), .N_ARCH(N_ARCH),
      .N_SCR(N_SCR), .IDX_W(IDX_W)
    ) u_rd (
      .idx_i     (src_idx[p]),
      .fut_val_i (fut_val),
      .fut_vld_i (fut_valid),
      .fut_tag_i (fut_tag),
      .com_val_i (com_val),
      .ready_o   (src_ready[p]),
      .data_o    (src_data[p]),
      .tag_o     (src_tag[p])
    );
  end
endmodule

// File: rtl/iff_regfile_chk.sv
module iff_regfile_chk #(
  parameter int DATA_W = 32,
  parameter int TAG_W  = 8,
  parameter int N_ARCH = 16,
  parameter int N_SCR  = 8,
  parameter int N_SRC  = 2,
  localparam int N_ENT = N_ARCH + N_SCR,
  localparam int IDX_W = $clog2(N_ENT),
  localparam int AW    = $clog2(N_ARCH)
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          flush,
  input logic                          disp_en,
  input logic                          disp_dst_en,
  input logic [IDX_W-1:0]              disp_dst,
  input logic [TAG_W-1:0]              disp_tag,
  input logic [N_SRC-1:0][IDX_W-1:0]   src_idx,
  input logic [N_SRC-1:0]              src_ready,
  input logic                          cmp_en,
  input logic [IDX_W-1:0]              cmp_idx,
  input logic [TAG_W-1:0]              cmp_tag,
  input logic [DATA_W-1:0]             cmp_data,
  input logic                          ret_en,
  input logic [IDX_W-1:0]              ret_idx,
  input logic [DATA_W-1:0]             ret_data,
  input logic [N_ARCH-1:0][DATA_W-1:0] fut_val,
  input logic [N_ARCH-1:0]             fut_valid,
  input logic [N_ARCH-1:0][TAG_W-1:0]  fut_tag,
  input logic [N_ENT-1:0][DATA_W-1:0]  com_val
);
  logic [AW-1:0] dsel, csel;
  logic d_arch, c_arch, same, match;

  assign dsel   = disp_dst[AW-1:0];
  assign csel   = cmp_idx[AW-1:0];
  assign d_arch = disp_en && disp_dst_en && !flush && (disp_dst < IDX_W'(N_ARCH));
  assign c_arch = cmp_en && !flush && (cmp_idx < IDX_W'(N_ARCH));
  assign same   = d_arch && (dsel == csel);
  assign match  = (fut_tag[csel] == cmp_tag);

  // R4 R7
  disp_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    d_arch |=> (!fut_valid[$past(dsel)] && fut_tag[$past(dsel)] == $past(disp_tag)));

  // R5
  cmp_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (c_arch && match && !same) |=>
      (fut_valid[$past(csel)] && fut_val[$past(csel)] == $past(cmp_data)));

  // R6
  cmp_stale_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (c_arch && !match && !same) |=>
      (fut_val[$past(csel)] == $past(fut_val[csel]) &&
       fut_valid[$past(csel)] == $past(fut_valid[csel]) &&
       fut_tag[$past(csel)] == $past(fut_tag[csel])));

  // R8
  retire_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_en && ret_idx < IDX_W'(N_ENT)) |=> (com_val[$past(ret_idx)] == $past(ret_data)));

  // R9
  flush_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> ((&fut_valid) && fut_val == $past(com_val[N_ARCH-1:0])));

  for (genvar p = 0; p < N_SRC; p++) begin : g_scr
    // R10
    scratch_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (src_idx[p] >= IDX_W'(N_ARCH)) |-> src_ready[p]);
  end
endmodule

bind iff_regfile iff_regfile_chk #(
  .DATA_W(DATA_W), .TAG_W(TAG_W), .N_ARCH(N_ARCH), .N_SCR(N_SCR), .N_SRC(N_SRC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .disp_en(disp_en),
  .disp_dst_en(disp_dst_en), .disp_dst(disp_dst), .disp_tag(disp_tag),
  .src_idx(src_idx), .src_ready(src_ready), .cmp_en(cmp_en),
  .cmp_idx(cmp_idx), .cmp_tag(cmp_tag), .cmp_data(cmp_data),
  .ret_en(ret_en), .ret_idx(ret_idx), .ret_data(ret_data),
  .fut_val(fut_val), .fut_valid(fut_valid), .fut_tag(fut_tag),
  .com_val(com_val)
);

// File: tb/iff_regfile_test.sv
`timescale 1ns/1ps
module iff_regfile_test;
  localparam int DW = 32, TW = 8, NA = 16, NS = 8, NE = 24, IW = 5;

  logic clk, rst_n, flush, disp_en, disp_dst_en, cmp_en, ret_en;
  logic [IW-1:0] disp_dst, cmp_idx, ret_idx;
  logic [TW-1:0] disp_tag, cmp_tag;
  logic [DW-1:0] cmp_data, ret_data;
  logic [1:0][IW-1:0] src_idx;
  logic [1:0]         src_ready;
  logic [1:0][DW-1:0] src_data;
  logic [1:0][TW-1:0] src_tag;

  int checks = 0, fails = 0;
  bit done = 0;

  typedef struct {
    string         req;
    int            port;
    int            idx;
    logic          rdy;
    logic [DW-1:0] data;
    logic [TW-1:0] tag;
  } exp_t;
  exp_t exp_q[$];

  logic [DW-1:0] m_com [NE];
  logic [DW-1:0] m_fut [NA];
  logic          m_vld [NA];
  logic [TW-1:0] m_tag [NA];

  iff_regfile uut (
    .clk(clk), .rst_n(rst_n), .flush(flush), .disp_en(disp_en),
    .disp_dst_en(disp_dst_en), .disp_dst(disp_dst), .disp_tag(disp_tag),
    .src_idx(src_idx), .src_ready(src_ready), .src_data(src_data),
    .src_tag(src_tag), .cmp_en(cmp_en), .cmp_idx(cmp_idx), .cmp_tag(cmp_tag),
    .cmp_data(cmp_data), .ret_en(ret_en), .ret_idx(ret_idx), .ret_data(ret_data)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic idle();
    flush = 0; disp_en = 0; disp_dst_en = 0; disp_dst = '0; disp_tag = '0;
    cmp_en = 0; cmp_idx = '0; cmp_tag = '0; cmp_data = '0;
    ret_en = 0; ret_idx = '0; ret_data = '0;
  endtask

  // Driver: push expected lookups from the model, then advance the model at the edge.
  task automatic tick(input string req);
    for (int p = 0; p < 2; p++) begin
      exp_t e;
      int   i;
      i = int'(src_idx[p]);
      e.port = p; e.idx = i; e.tag = '0; e.data = '0; e.rdy = 1'b1;
      if (i < NA) begin
        e.rdy = m_vld[i]; e.data = m_fut[i]; e.tag = m_tag[i];
      end else if (i < NE) begin
        e.data = m_com[i];
      end
      if (req != "")   e.req = req;
      else if (i >= NA) e.req = "R10";
      else if (e.rdy)   e.req = "R2";
      else              e.req = "R3";
      exp_q.push_back(e);
    end
    @(posedge clk);
    if (flush) begin
      for (int i = 0; i < NA; i++) begin m_fut[i] = m_com[i]; m_vld[i] = 1'b1; end
    end else begin
      bool_upd();
    end
    if (ret_en && int'(ret_idx) < NE) m_com[ret_idx] = ret_data;
  endtask

  task automatic bool_upd();
    bit dh, ch;
    dh = disp_en && disp_dst_en && int'(disp_dst) < NA;
    ch = cmp_en && int'(cmp_idx) < NA && m_tag[cmp_idx[3:0]] == cmp_tag;
    if (ch && !(dh && disp_dst == cmp_idx)) begin
      m_fut[cmp_idx[3:0]] = cmp_data; m_vld[cmp_idx[3:0]] = 1'b1;
    end
    if (dh) begin
      m_tag[disp_dst[3:0]] = disp_tag; m_vld[disp_dst[3:0]] = 1'b0;
    end
  endtask

  // Monitor: compare outputs in the low phase, before the next rising edge.
  initial begin
    forever begin
      @(negedge clk);
      #2;
      while (exp_q.size() > 0) begin
        exp_t e;
        bit bad;
        e = exp_q.pop_front();
        checks++;
        bad = (src_ready[e.port] !== e.rdy) ||
              (e.rdy && src_data[e.port] !== e.data) ||
              (!e.rdy && src_tag[e.port] !== e.tag);
        if (bad) begin
          fails++;
          $display("FAIL %s idx %0d port %0d: ready=%0b data=%h tag=%h, expected ready=%0b data=%h tag=%h",
                   e.req, e.idx, e.port, src_ready[e.port], src_data[e.port],
                   src_tag[e.port], e.rdy, e.data, e.tag);
        end
      end
    end
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NE; i++) m_com[i] = '0;
    for (int i = 0; i < NA; i++) begin m_fut[i] = '0; m_vld[i] = 1'b1; m_tag[i] = '0; end
    idle();
    src_idx = '0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;

    // R1: every index ready with zero after reset, plus out-of-range indices (R10)
    for (int i = 0; i < 32; i += 2) begin
      @(negedge clk); idle(); src_idx[0] = IW'(i); src_idx[1] = IW'(i + 1);
      tick(i < NE ? "R1" : "R10");
    end

    // R8: retire to an architectural and a scratch index
    @(negedge clk); idle(); ret_en = 1; ret_idx = 5'd3; ret_data = 32'h33; tick("R8");
    @(negedge clk); idle(); ret_en = 1; ret_idx = 5'd17; ret_data = 32'h77; tick("R8");
    @(negedge clk); idle(); src_idx[0] = 5'd3; src_idx[1] = 5'd17; tick("R8");

    // R4: dispatch whose source equals its destination sees the old state
    @(negedge clk); idle(); disp_en = 1; disp_dst_en = 1; disp_dst = 5'd5; disp_tag = 8'h21;
    src_idx[0] = 5'd5; src_idx[1] = 5'd5; tick("R4");
    // R4: dispatch enable low leaves the destination untouched
    @(negedge clk); idle(); disp_dst_en = 1; disp_dst = 5'd6; disp_tag = 8'h99;
    src_idx[0] = 5'd5; src_idx[1] = 5'd6; tick("R4");
    @(negedge clk); idle(); src_idx[0] = 5'd6; src_idx[1] = 5'd5; tick("R4");

    // R6: stale completion
    @(negedge clk); idle(); cmp_en = 1; cmp_idx = 5'd5; cmp_tag = 8'h20; cmp_data = 32'hdead;
    tick("R6");
    @(negedge clk); idle(); src_idx[0] = 5'd5; tick("R6");

    // R7: dispatch and matching completion on the same entry
    @(negedge clk); idle(); disp_en = 1; disp_dst_en = 1; disp_dst = 5'd5; disp_tag = 8'h42;
    cmp_en = 1; cmp_idx = 5'd5; cmp_tag = 8'h21; cmp_data = 32'h1111; tick("R7");
    @(negedge clk); idle(); src_idx[0] = 5'd5; tick("R7");

    // R5: matching completion
    @(negedge clk); idle(); cmp_en = 1; cmp_idx = 5'd5; cmp_tag = 8'h42; cmp_data = 32'hbeef;
    tick("R5");
    @(negedge clk); idle(); src_idx[0] = 5'd5; src_idx[1] = 5'd3; tick("R5");

    // R10: dispatch and completion to a scratch index have no effect
    @(negedge clk); idle(); disp_en = 1; disp_dst_en = 1; disp_dst = 5'd17; disp_tag = 8'h09;
    cmp_en = 1; cmp_idx = 5'd17; cmp_tag = 8'h00; cmp_data = 32'h5555; tick("R10");
    @(negedge clk); idle(); src_idx[0] = 5'd17; src_idx[1] = 5'd25; tick("R10");

    // R9: flush with competing dispatch, completion and retirement
    @(negedge clk); idle(); disp_en = 1; disp_dst_en = 1; disp_dst = 5'd6; disp_tag = 8'h55;
    tick("R9");
    @(negedge clk); idle(); flush = 1; disp_en = 1; disp_dst_en = 1; disp_dst = 5'd7;
    disp_tag = 8'h66; cmp_en = 1; cmp_idx = 5'd6; cmp_tag = 8'h55; cmp_data = 32'h4444;
    ret_en = 1; ret_idx = 5'd6; ret_data = 32'h600; tick("R9");
    @(negedge clk); idle(); src_idx[0] = 5'd6; src_idx[1] = 5'd7; tick("R9");
    @(negedge clk); idle(); src_idx[0] = 5'd5; src_idx[1] = 5'd3; tick("R9");
    @(negedge clk); idle(); flush = 1; tick("R9");
    @(negedge clk); idle(); src_idx[0] = 5'd6; src_idx[1] = 5'd3; tick("R9");

    // Random mix of all operations
    for (int n = 0; n < 2000; n++) begin
      @(negedge clk); idle();
      disp_en     = ($urandom_range(1) == 1);
      disp_dst_en = ($urandom_range(3) != 0);
      disp_dst    = IW'($urandom_range(19));
      disp_tag    = TW'($urandom);
      cmp_en      = ($urandom_range(1) == 1);
      cmp_idx     = IW'($urandom_range(19));
      cmp_tag     = ($urandom_range(1) == 1 && int'(cmp_idx) < NA) ? m_tag[cmp_idx[3:0]]
                                                                   : TW'($urandom);
      cmp_data    = $urandom;
      ret_en      = ($urandom_range(2) == 0);
      ret_idx     = IW'($urandom_range(25));
      ret_data    = $urandom;
      flush       = ($urandom_range(24) == 0);
      src_idx[0]  = IW'($urandom_range(25));
      src_idx[1]  = IW'($urandom_range(17));
      tick("");
    end

    @(negedge clk); idle();
    @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule